// File: doc/BRIEF.md
# Chained Front-End Link Node

This block is one node in a serial chain of front-end boards that all report to a single readout concentrator. It has two word streams. One stream runs away from the concentrator: words come in from the near side and go out to the far side. The other stream runs toward the concentrator: words come in from the far side and go out to the near side. Every word is 34 bits wide. Bits [33:32] give the word kind, where 0 is init, 1 is request, 2 is response or data, and 3 is token. Bits [31:0] are the payload.

The node does four jobs. First, it takes a module id while the chain is being numbered. Second, it serves read and write requests addressed to that id through a simple local register port. Third, it forwards all other traffic unchanged. Fourth, when it receives a readout token, it sends the contents of a local buffer toward the concentrator and then passes the token on. Words arriving from the far side go through a pass-through FIFO without being changed. An arbiter merges that FIFO with the node's own packets and never lets the words of two packets interleave. The node works out by itself whether it is the last node in the chain. When it is last, it returns the token toward the concentrator after its own packet.

Top module: `chain_link_node`

## Requirements
- R1: An init word on the near-side input sets the node id to payload[9:0] and raises id_valid. One edge later the far-side output carries an init word whose payload[9:0] is that id plus one, with the other payload bits zero.
- R2: A request word has payload[31] = write, [30:21] = target id, [20:16] = register address and [15:0] = write data. When the target matches the node id, the register strobe for the request (write or read) is asserted in the same cycle as the request word.
- R3: A near-side input word is forwarded unchanged on the far-side output one edge later when it is either a response word or a request whose target does not match the node id.
- R4: Words arriving on the far-side input reach the near-side output unchanged and in arrival order. When the node is idle, each word appears two edges after it is sampled.
- R5: A matching request produces one response word toward the concentrator, two edges after the request when the node is idle. The response payload has [31] = 1, [30] = 1 for a read and 0 for a write, [29:20] = node id, [19:16] = 0, and [15:0] = the read data (zero for a write).
- R6: On a token word (kind 3), the node sends a header word with payload [31:30] = 01, [29:20] = node id and [15:0] = buffer length. It then sends one data word per buffer entry, with payload [15:0] = the entry, the other bits zero, and entries in address order. If the node is not last, a token with payload 0 leaves on the far-side output one edge after the final word of the packet.
- R7: With wait_mode high, the packet is held back until buf_ready is high, and the header leaves on the edge where buf_ready is first seen high. With wait_mode low, the header leaves two edges after the token, whatever the state of buf_ready.
- R8: A node that is last sends a token with payload 1 toward the concentrator on the edge right after the final word of its packet, and sends no token on the far-side output.
- R9: Pass-through words win arbitration whenever the node is not partway through its own packet. A local packet is never split by pass-through words, and words that arrive during a packet follow it directly.
- R10: is_last goes high INIT_TIMEOUT cycles after numbering if no init word has arrived on the far-side input. It stays low if one did arrive.
- R11: After reset, both outputs are idle and id_valid and is_last are low.
- R12: Numbering also sends an init word carrying the node's own id toward the concentrator, two edges after the init word is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dn_in_valid | input | 1 | Word valid from the concentrator side |
| dn_in_word | input | 34 | Word from the concentrator side |
| up_out_valid | output | 1 | Word valid toward the far side |
| up_out_word | output | 34 | Word toward the far side |
| up_in_valid | input | 1 | Word valid from the far side |
| up_in_word | input | 34 | Word from the far side |
| dn_out_valid | output | 1 | Word valid toward the concentrator |
| dn_out_word | output | 34 | Word toward the concentrator |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, combinational from reg_addr |
| wait_mode | input | 1 | 1: hold the token until buffer ready; 0: send on arrival |
| buf_ready | input | 1 | Local buffer declared ready |
| buf_len | input | 9 | Number of buffer entries to send |
| buf_rd_addr | output | 8 | Buffer read address |
| buf_rd_data | input | 16 | Buffer entry, combinational from buf_rd_addr |
| buf_release | output | 1 | One-cycle pulse when the packet has been sent |
| node_id | output | 10 | Assigned module id |
| id_valid | output | 1 | An id has been assigned |
| is_last | output | 1 | Node detected as last in the chain |

## Verification
Far-side forwards and numbering words are due one edge after the input is sampled. Responses, echoes and pass-through words are due two edges after, provided the node is idle. A token packet starts two edges after the token, or on the edge where buf_ready is seen in wait mode, and then runs one word per edge. The forwarded token follows one edge after the final word. The bench keeps a behavioural model that holds, for every expected word, both its value and the edge number on which it is due. On each falling clock it compares the live outputs against the head of that model, so a word that is early, late, missing, altered or unexpected is reported. Arbitration is tested by feeding far-side words during a packet, and by feeding a far-side word and a matching request in the same cycle.

// File: rtl/chain_link_pkg.sv
`timescale 1ns/1ps
package chain_link_pkg;
    localparam int PAY_W   = 32;
    localparam int WORD_W  = PAY_W + 2;
    localparam int ID_W    = 10;
    localparam int RADDR_W = 5;
    localparam int RDATA_W = 16;

    typedef enum logic [1:0] {
        K_INIT = 2'd0,
        K_REQ  = 2'd1,
        K_RSP  = 2'd2,
        K_TOK  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [PAY_W-1:0]  pay;
    } word_t;

    typedef struct packed {
        logic               wr;
        logic [ID_W-1:0]    tgt;
        logic [RADDR_W-1:0] addr;
        logic [RDATA_W-1:0] wdata;
    } req_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_RET  = 2'd2
    } tx_st_e;

    function automatic word_t mk_init(input logic [ID_W-1:0] id);
        word_t w;
        w.kind = K_INIT;
        w.pay  = '0;
        w.pay[ID_W-1:0] = id;
        return w;
    endfunction

    function automatic word_t mk_resp(input logic is_rd, input logic [ID_W-1:0] id,
                                      input logic [RDATA_W-1:0] d);
        word_t w;
        w.kind = K_RSP;
        w.pay  = {1'b1, is_rd, id, 4'b0, d};
        return w;
    endfunction

    function automatic word_t mk_hdr(input logic [ID_W-1:0] id, input logic [15:0] len);
        word_t w;
        w.kind = K_RSP;
        w.pay  = {2'b01, id, 4'b0, len};
        return w;
    endfunction

    function automatic word_t mk_data(input logic [RDATA_W-1:0] d);
        word_t w;
        w.kind = K_RSP;
        w.pay  = {16'b0, d};
        return w;
    endfunction

    function automatic word_t mk_tok(input logic ret);
        word_t w;
        w.kind = K_TOK;
        w.pay  = {31'b0, ret};
        return w;
    endfunction
endpackage

// File: rtl/cln_pass_fifo.sv
`timescale 1ns/1ps
module cln_pass_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          full, do_wr, do_rd;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4: pass-through traffic must never be dropped
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && full));
endmodule

// File: rtl/cln_rx_ctrl.sv
`timescale 1ns/1ps
module cln_rx_ctrl import chain_link_pkg::*; #(
    parameter int INIT_TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               far_valid,
    input  logic [1:0]         far_kind,
    input  logic               tok_fwd_req,
    input  logic [RDATA_W-1:0] reg_rdata,
    output logic               up_valid,
    output logic [WORD_W-1:0]  up_word,
    output logic               reg_wr_en,
    output logic               reg_rd_en,
    output logic [RADDR_W-1:0] reg_addr,
    output logic [RDATA_W-1:0] reg_wdata,
    output logic               resp_valid,
    output word_t              resp_word,
    output logic               echo_req,
    output logic               tok_arrive,
    output logic [ID_W-1:0]    my_id,
    output logic               id_valid,
    output logic               is_last
);
    localparam int TO_W = $clog2(INIT_TIMEOUT + 1);
    localparam logic [TO_W-1:0] TO_MAX = TO_W'(INIT_TIMEOUT);

    word_t           iw;
    req_t            rq;
    logic            is_init, is_req, hit, pass, is_tok, tok_send;
    logic            tok_pend, saw_echo;
    logic [TO_W-1:0] timer;

    always_comb begin
        iw       = word_t'(in_word);
        rq       = req_t'(iw.pay);
        is_init  = in_valid && (iw.kind == K_INIT);
        is_req   = in_valid && (iw.kind == K_REQ);
        is_tok   = in_valid && (iw.kind == K_TOK);
        hit      = is_req && id_valid && (rq.tgt == my_id);
        pass     = (is_req && !hit) || (in_valid && (iw.kind == K_RSP));
        tok_send = tok_pend || tok_fwd_req;
    end

    assign reg_wr_en = hit && rq.wr;
    assign reg_rd_en = hit && !rq.wr;
    assign reg_addr  = rq.addr;
    assign reg_wdata = rq.wdata;
    assign is_last   = id_valid && (timer == TO_MAX) && !saw_echo;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_valid   <= 1'b0;
            up_word    <= '0;
            tok_pend   <= 1'b0;
            my_id      <= '0;
            id_valid   <= 1'b0;
            timer      <= '0;
            saw_echo   <= 1'b0;
            echo_req   <= 1'b0;
            resp_valid <= 1'b0;
            resp_word  <= '0;
            tok_arrive <= 1'b0;
        end else begin
            up_valid <= is_init || pass || tok_send;
            if (is_init)       up_word <= mk_init(iw.pay[ID_W-1:0] + 1'b1);
            else if (pass)     up_word <= in_word;
            else if (tok_send) up_word <= mk_tok(1'b0);
            tok_pend <= tok_send && (is_init || pass);

            echo_req <= is_init;
            if (is_init) begin
                my_id    <= iw.pay[ID_W-1:0];
                id_valid <= 1'b1;
                timer    <= '0;
                saw_echo <= 1'b0;
            end else begin
                if (id_valid && timer != TO_MAX) timer <= timer + 1'b1;
                if (id_valid && far_valid && far_kind == K_INIT) saw_echo <= 1'b1;
            end

            resp_valid <= hit;
            resp_word  <= mk_resp(!rq.wr, my_id, rq.wr ? '0 : reg_rdata);
            tok_arrive <= is_tok;
        end
    end

    // R1: numbering forwards the next id one edge later
    p_init_incr_r1: assert property (@(posedge clk) disable iff (rst)
        is_init |=> (up_valid && up_word[WORD_W-1:WORD_W-2] == 2'd0 &&
                     up_word[ID_W-1:0] == $past(in_word[ID_W-1:0]) + 1'b1));
    // R3: traffic not for this node leaves unchanged one edge later
    p_up_fwd_r3: assert property (@(posedge clk) disable iff (rst)
        (is_req && !hit) |=> (up_valid && up_word == $past(in_word)));
    // R2: a response is only produced for a request seen on the previous edge
    p_resp_src_r2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(is_req));
endmodule

// File: rtl/cln_tx_ctrl.sv
`timescale 1ns/1ps
module cln_tx_ctrl import chain_link_pkg::*; #(
    parameter int BUF_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               resp_valid,
    input  word_t              resp_word,
    input  logic               echo_req,
    input  logic               tok_arrive,
    input  logic [ID_W-1:0]    my_id,
    input  logic               is_last,
    input  logic               wait_mode,
    input  logic               buf_ready,
    input  logic [BUF_AW:0]    buf_len,
    input  logic [RDATA_W-1:0] buf_rd_data,
    input  logic               fifo_empty,
    input  logic [WORD_W-1:0]  fifo_rdata,
    output logic               fifo_rd,
    output logic [BUF_AW-1:0]  buf_rd_addr,
    output logic               buf_release,
    output logic               tok_fwd_req,
    output logic               dn_valid,
    output logic [WORD_W-1:0]  dn_word
);
    tx_st_e         st, st_n;
    logic           echo_p, resp_p, tok_p;
    logic           echo_n, resp_n, tok_n;
    logic           e_clr, r_clr, launch, finish, nxt_valid;
    word_t          resp_q, resp_sel, nxt_word;
    logic [BUF_AW:0] cnt, cnt_n, len_q, len_n;

    assign buf_rd_addr = cnt[BUF_AW-1:0];

    always_comb begin
        echo_n    = echo_p || echo_req;
        resp_n    = resp_p || resp_valid;
        tok_n     = tok_p || tok_arrive;
        resp_sel  = resp_valid ? resp_word : resp_q;
        fifo_rd   = 1'b0;
        nxt_valid = 1'b0;
        nxt_word  = '0;
        e_clr     = 1'b0;
        r_clr     = 1'b0;
        launch    = 1'b0;
        finish    = 1'b0;
        st_n      = st;
        cnt_n     = cnt;
        len_n     = len_q;
        case (st)
            TX_IDLE: begin
                if (!fifo_empty) begin
                    fifo_rd   = 1'b1;
                    nxt_valid = 1'b1;
                    nxt_word  = word_t'(fifo_rdata);
                end else if (echo_n) begin
                    nxt_valid = 1'b1;
                    nxt_word  = mk_init(my_id);
                    e_clr     = 1'b1;
                end else if (resp_n) begin
                    nxt_valid = 1'b1;
                    nxt_word  = resp_sel;
                    r_clr     = 1'b1;
                end else if (tok_n && (!wait_mode || buf_ready)) begin
                    launch    = 1'b1;
                    nxt_valid = 1'b1;
                    nxt_word  = mk_hdr(my_id, 16'(buf_len));
                    len_n     = buf_len;
                    cnt_n     = '0;
                    if (buf_len == '0) finish = 1'b1;
                    else               st_n   = TX_DATA;
                end
            end
            TX_DATA: begin
                nxt_valid = 1'b1;
                nxt_word  = mk_data(buf_rd_data);
                cnt_n     = cnt + 1'b1;
                if (cnt == len_q - 1'b1) finish = 1'b1;
            end
            TX_RET: begin
                nxt_valid = 1'b1;
                nxt_word  = mk_tok(1'b1);
                st_n      = TX_IDLE;
            end
            default: st_n = TX_IDLE;
        endcase
        if (finish) st_n = is_last ? TX_RET : TX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= TX_IDLE;
            echo_p      <= 1'b0;
            resp_p      <= 1'b0;
            tok_p       <= 1'b0;
            resp_q      <= '0;
            cnt         <= '0;
            len_q       <= '0;
            dn_valid    <= 1'b0;
            dn_word     <= '0;
            buf_release <= 1'b0;
            tok_fwd_req <= 1'b0;
        end else begin
            st          <= st_n;
            echo_p      <= echo_n && !e_clr;
            resp_p      <= resp_n && !r_clr;
            tok_p       <= tok_n && !launch;
            if (resp_valid) resp_q <= resp_word;
            cnt         <= cnt_n;
            len_q       <= len_n;
            dn_valid    <= nxt_valid;
            dn_word     <= nxt_word;
            buf_release <= finish;
            tok_fwd_req <= finish && !is_last;
        end
    end

    // R9: no pass-through word is taken while a local packet is in flight
    p_no_mix_r9: assert property (@(posedge clk) disable iff (rst)
        (st == TX_DATA || st == TX_RET) |-> !fifo_rd);
    // R6: the token is only released alongside the final packet word
    p_tok_after_pkt_r6: assert property (@(posedge clk) disable iff (rst)
        tok_fwd_req |-> (dn_valid && buf_release));
endmodule

// File: rtl/chain_link_node.sv
`timescale 1ns/1ps
module chain_link_node import chain_link_pkg::*; #(
    parameter int FIFO_DEPTH   = 16,
    parameter int INIT_TIMEOUT = 64,
    parameter int BUF_AW       = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dn_in_valid,
    input  logic [WORD_W-1:0]  dn_in_word,
    output logic               up_out_valid,
    output logic [WORD_W-1:0]  up_out_word,
    input  logic               up_in_valid,
    input  logic [WORD_W-1:0]  up_in_word,
    output logic               dn_out_valid,
    output logic [WORD_W-1:0]  dn_out_word,
    output logic               reg_wr_en,
    output logic               reg_rd_en,
    output logic [RADDR_W-1:0] reg_addr,
    output logic [RDATA_W-1:0] reg_wdata,
    input  logic [RDATA_W-1:0] reg_rdata,
    input  logic               wait_mode,
    input  logic               buf_ready,
    input  logic [BUF_AW:0]    buf_len,
    output logic [BUF_AW-1:0]  buf_rd_addr,
    input  logic [RDATA_W-1:0] buf_rd_data,
    output logic               buf_release,
    output logic [ID_W-1:0]    node_id,
    output logic               id_valid,
    output logic               is_last
);
    logic              fifo_rd, fifo_empty;
    logic [WORD_W-1:0] fifo_rdata;
    logic              resp_valid, echo_req, tok_arrive, tok_fwd_req;
    word_t             resp_word;

    cln_pass_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(up_in_valid), .wr_data(up_in_word),
        .rd_en(fifo_rd), .rd_data(fifo_rdata), .empty(fifo_empty)
    );

    cln_rx_ctrl #(.INIT_TIMEOUT(INIT_TIMEOUT)) u_rx (
        .clk(clk), .rst(rst),
        .in_valid(dn_in_valid), .in_word(dn_in_word),
        .far_valid(up_in_valid), .far_kind(up_in_word[WORD_W-1:WORD_W-2]),
        .tok_fwd_req(tok_fwd_req), .reg_rdata(reg_rdata),
        .up_valid(up_out_valid), .up_word(up_out_word),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .resp_valid(resp_valid), .resp_word(resp_word),
        .echo_req(echo_req), .tok_arrive(tok_arrive),
        .my_id(node_id), .id_valid(id_valid), .is_last(is_last)
    );

    cln_tx_ctrl #(.BUF_AW(BUF_AW)) u_tx (
        .clk(clk), .rst(rst),
        .resp_valid(resp_valid), .resp_word(resp_word),
        .echo_req(echo_req), .tok_arrive(tok_arrive),
        .my_id(node_id), .is_last(is_last),
        .wait_mode(wait_mode), .buf_ready(buf_ready), .buf_len(buf_len),
        .buf_rd_data(buf_rd_data),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
        .buf_rd_addr(buf_rd_addr), .buf_release(buf_release),
        .tok_fwd_req(tok_fwd_req),
        .dn_valid(dn_out_valid), .dn_word(dn_out_word)
    );
endmodule

// File: tb/test_chain_link_node.sv
`timescale 1ns/1ps
module test_chain_link_node;
    logic        clk = 1'b0;
    logic        rst;
    logic        dn_in_valid, up_in_valid;
    logic [33:0] dn_in_word, up_in_word;
    logic        up_out_valid, dn_out_valid;
    logic [33:0] up_out_word, dn_out_word;
    logic        reg_wr_en, reg_rd_en;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        wait_mode, buf_ready, buf_release;
    logic [8:0]  buf_len;
    logic [7:0]  buf_rd_addr;
    logic [15:0] buf_rd_data;
    logic [9:0]  node_id;
    logic        id_valid, is_last;

    always #10 clk = ~clk;

    chain_link_node i_chain_link_node (.*);

    logic [15:0] rf [32];
    assign reg_rdata   = rf[reg_addr];
    assign buf_rd_data = 16'hB000 + {8'h00, buf_rd_addr};
    always @(posedge clk) if (reg_wr_en) rf[reg_addr] <= reg_wdata;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0, dn_seen = 0;
    bit mon_on = 0, done = 0;

    logic [33:0] eq_dn[$], eq_up[$];
    int          dq_dn[$], dq_up[$];
    string       tg_dn[$], tg_up[$];

    function automatic logic [33:0] w_init(input logic [9:0] id);
        return {2'b00, 22'b0, id};
    endfunction
    function automatic logic [33:0] w_req(input logic wr, input logic [9:0] tgt,
                                          input logic [4:0] a, input logic [15:0] d);
        return {2'b01, wr, tgt, a, d};
    endfunction
    function automatic logic [33:0] w_rsp(input logic rd, input logic [9:0] id, input logic [15:0] d);
        return {2'b10, 1'b1, rd, id, 4'b0, d};
    endfunction
    function automatic logic [33:0] w_hdr(input logic [9:0] id, input logic [15:0] len);
        return {2'b10, 2'b01, id, 4'b0, len};
    endfunction
    function automatic logic [33:0] w_dat(input logic [15:0] d);
        return {2'b10, 16'b0, d};
    endfunction
    function automatic logic [33:0] w_tok(input logic r);
        return {2'b11, 31'b0, r};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_dn(input logic [33:0] w, input int due, input string tag);
        eq_dn.push_back(w); dq_dn.push_back(due); tg_dn.push_back(tag);
    endtask
    task automatic exp_up(input logic [33:0] w, input int due, input string tag);
        eq_up.push_back(w); dq_up.push_back(due); tg_up.push_back(tag);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (dn_out_valid) begin
                dn_seen++;
                if (eq_dn.size() == 0) chk(0, "R9 unexpected near-side word", dn_out_word, 0);
                else begin
                    logic [33:0] w; int d; string t;
                    w = eq_dn.pop_front(); d = dq_dn.pop_front(); t = tg_dn.pop_front();
                    chk(dn_out_word === w, t, dn_out_word, w);
                    chk(cyc == d, {t, " timing"}, cyc, d);
                end
            end else if (eq_dn.size() > 0 && dq_dn[0] < cyc) begin
                chk(0, {tg_dn[0], " missing"}, 0, eq_dn[0]);
                void'(eq_dn.pop_front()); void'(dq_dn.pop_front()); void'(tg_dn.pop_front());
            end
            if (up_out_valid) begin
                if (eq_up.size() == 0) chk(0, "R3 unexpected far-side word", up_out_word, 0);
                else begin
                    logic [33:0] w; int d; string t;
                    w = eq_up.pop_front(); d = dq_up.pop_front(); t = tg_up.pop_front();
                    chk(up_out_word === w, t, up_out_word, w);
                    chk(cyc == d, {t, " timing"}, cyc, d);
                end
            end else if (eq_up.size() > 0 && dq_up[0] < cyc) begin
                chk(0, {tg_up[0], " missing"}, 0, eq_up[0]);
                void'(eq_up.pop_front()); void'(dq_up.pop_front()); void'(tg_up.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int e, b, s;
        for (int i = 0; i < 32; i++) rf[i] = 16'h0;
        rst = 1; dn_in_valid = 0; up_in_valid = 0; dn_in_word = '0; up_in_word = '0;
        wait_mode = 0; buf_ready = 0; buf_len = '0;
        tick(5);
        rst = 0;
        tick(1);
        chk(dn_out_valid == 0, "R11 near-side idle", dn_out_valid, 0);
        chk(up_out_valid == 0, "R11 far-side idle", up_out_valid, 0);
        chk(id_valid == 0, "R11 id_valid low", id_valid, 0);
        chk(is_last == 0, "R11 is_last low", is_last, 0);
        mon_on = 1;

        // numbering as id 3
        dn_in_valid = 1; dn_in_word = w_init(10'd3); e = cyc + 1;
        exp_up(w_init(10'd4), e, "R1 next id forwarded");
        exp_dn(w_init(10'd3), e + 1, "R12 own id echoed");
        tick(1); dn_in_valid = 0;
        tick(2);
        chk(node_id == 10'd3 && id_valid, "R1 id stored", node_id, 3);
        tick(70);
        chk(is_last == 1, "R10 last after timeout", is_last, 1);

        // write then read of register 5
        dn_in_valid = 1; dn_in_word = w_req(1'b1, 10'd3, 5'd5, 16'h1234); e = cyc + 1;
        exp_dn(w_rsp(1'b0, 10'd3, 16'h0), e + 1, "R5 write ack");
        tick(1); dn_in_valid = 0;
        tick(3);
        chk(rf[5] == 16'h1234, "R2 write reached register port", rf[5], 16'h1234);
        dn_in_valid = 1; dn_in_word = w_req(1'b0, 10'd3, 5'd5, 16'h0); e = cyc + 1;
        exp_dn(w_rsp(1'b1, 10'd3, 16'h1234), e + 1, "R2 R5 read ack with data");
        tick(1); dn_in_valid = 0;
        tick(3);

        // request for another node, and a stray response word
        dn_in_valid = 1; dn_in_word = w_req(1'b1, 10'd7, 5'd2, 16'hBEEF); e = cyc + 1;
        exp_up(w_req(1'b1, 10'd7, 5'd2, 16'hBEEF), e, "R3 foreign request forwarded");
        tick(1);
        dn_in_word = w_rsp(1'b1, 10'd9, 16'h55AA); e = cyc + 1;
        exp_up(w_rsp(1'b1, 10'd9, 16'h55AA), e, "R3 response forwarded");
        tick(1); dn_in_valid = 0;
        tick(3);
        chk(rf[2] == 16'h0, "R3 foreign write left register untouched", rf[2], 0);

        // pass-through burst from the far side
        for (int k = 0; k < 3; k++) begin
            up_in_valid = 1; up_in_word = w_dat(16'h7000 + 16'(k)); e = cyc + 1;
            exp_dn(w_dat(16'h7000 + 16'(k)), e + 1, "R4 pass-through word");
            tick(1);
        end
        up_in_valid = 0;
        tick(4);

        // no-wait token on the last node
        wait_mode = 0; buf_ready = 0; buf_len = 9'd3;
        dn_in_valid = 1; dn_in_word = w_tok(1'b0); e = cyc + 1;
        exp_dn(w_hdr(10'd3, 16'd3), e + 1, "R7 R6 header without ready");
        exp_dn(w_dat(16'hB000), e + 2, "R6 data 0");
        exp_dn(w_dat(16'hB001), e + 3, "R6 data 1");
        exp_dn(w_dat(16'hB002), e + 4, "R6 data 2");
        exp_dn(w_tok(1'b1), e + 5, "R8 returned token");
        tick(1); dn_in_valid = 0;
        tick(8);

        // renumber, this time with an echo from a farther node
        dn_in_valid = 1; dn_in_word = w_init(10'd3); e = cyc + 1;
        exp_up(w_init(10'd4), e, "R1 renumber forward");
        exp_dn(w_init(10'd3), e + 1, "R12 renumber echo");
        tick(1); dn_in_valid = 0;
        up_in_valid = 1; up_in_word = w_init(10'd4); e = cyc + 1;
        exp_dn(w_init(10'd4), e + 1, "R4 far echo passed through");
        tick(1); up_in_valid = 0;
        tick(70);
        chk(is_last == 0, "R10 not last when echo seen", is_last, 0);

        // wait-mode token
        wait_mode = 1; buf_ready = 0; buf_len = 9'd2;
        dn_in_valid = 1; dn_in_word = w_tok(1'b0);
        tick(1); dn_in_valid = 0;
        s = dn_seen;
        tick(10);
        chk(dn_seen == s, "R7 packet held until ready", dn_seen - s, 0);
        buf_ready = 1; b = cyc + 1;
        exp_dn(w_hdr(10'd3, 16'd2), b, "R7 header on ready");
        exp_dn(w_dat(16'hB000), b + 1, "R6 data 0");
        exp_dn(w_dat(16'hB001), b + 2, "R6 data 1");
        exp_up(w_tok(1'b0), b + 3, "R6 token forwarded after packet");
        tick(1); buf_ready = 0;
        tick(6);

        // far-side words arriving during a local packet
        wait_mode = 0; buf_len = 9'd3;
        dn_in_valid = 1; dn_in_word = w_tok(1'b0); e = cyc + 1;
        exp_dn(w_hdr(10'd3, 16'd3), e + 1, "R6 header");
        exp_dn(w_dat(16'hB000), e + 2, "R9 data 0 unbroken");
        exp_dn(w_dat(16'hB001), e + 3, "R9 data 1 unbroken");
        exp_dn(w_dat(16'hB002), e + 4, "R9 data 2 unbroken");
        exp_dn(w_dat(16'h6001), e + 5, "R9 held word 1 follows packet");
        exp_dn(w_dat(16'h6002), e + 6, "R9 held word 2 follows packet");
        exp_up(w_tok(1'b0), e + 5, "R6 token after final word");
        tick(1); dn_in_valid = 0;
        tick(1); up_in_valid = 1; up_in_word = w_dat(16'h6001);
        tick(1); up_in_word = w_dat(16'h6002);
        tick(1); up_in_valid = 0;
        tick(6);

        // pass-through beats a pending response
        up_in_valid = 1; up_in_word = w_dat(16'h4242);
        dn_in_valid = 1; dn_in_word = w_req(1'b0, 10'd3, 5'd5, 16'h0); e = cyc + 1;
        exp_dn(w_dat(16'h4242), e + 1, "R9 pass-through first");
        exp_dn(w_rsp(1'b1, 10'd3, 16'h1234), e + 2, "R9 response second");
        tick(1); up_in_valid = 0; dn_in_valid = 0;
        tick(6);

        chk(eq_dn.size() == 0, "R9 near-side model drained", eq_dn.size(), 0);
        chk(eq_up.size() == 0, "R3 far-side model drained", eq_up.size(), 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule